// File: doc/BRIEF.md
# BLDC Startup and Fault-Retry Supervisor

This block sequences the start of a sensorless three-phase brushless motor and recovers it after a speed fault. When the speed command rises above its threshold (`run_req_i`), the supervisor holds the rotor in a fixed DC-excitation position for a programmable number of clocks. It then runs an open-loop ramp in which it emits a forced commutation step at a fixed low rate. When back-EMF zero-cross strobes arrive faster than that forced rate, control passes to sensorless running.

While running, the supervisor times the interval between consecutive zero-cross strobes. An interval shorter than the over-speed limit is a fault. So is a gap as long as one forced step period with no strobe. On a fault, and also when the open-loop ramp runs out of time, the power stage is disabled. After a retry wait of about one second the whole startup sequence begins again, and this repeats for as long as faults recur. Withdrawing the run request sends the block back to idle at once from any phase.

Both rate limits come from the clock through power-of-two dividers. A three-level select picks the forced step period and a two-level select picks the over-speed limit, so the same block can serve 2 to 8 MHz clocks.

Top module: `bldc_start_sup`

## Requirements
- R1: After reset, `mode_o` is 0 (idle) and `enable_o`, `fault_o` and `step_o` are all 0. The mode encoding is: 0 idle, 1 align, 2 ramp, 3 run, 4 fault-wait.
- R2: In idle, a high `run_req_i` moves the mode to align on the next clock. Align lasts `align_cycles_i` clocks (at least one) and then moves to ramp.
- R3: The forced step period is 2^FST_SHIFT clocks when `fst_sel_i` is 2'b1x (high or open), 2^(FST_SHIFT+1) when it is 2'b01 (middle), and 2^(FST_SHIFT+2) when it is 2'b00 (low). In ramp, `step_o` pulses for one clock once per period, first in ramp cycle index P (counting from 0), and only while the mode is ramp.
- R4: In ramp, a zero-cross strobe that arrives less than one forced period after the previous strobe, both seen in ramp, moves the mode to run on the next clock. Run is entered only in this way.
- R5: If ramp lasts `ramp_cycles_i` clocks without a handover, the mode becomes fault-wait.
- R6: In run, a strobe whose interval from the previous strobe is shorter than the over-speed limit gives fault-wait. The limit is 2^FMAX_SHIFT clocks when `fmax_hi_i` is 1 and 2^(FMAX_SHIFT+1) clocks when it is 0.
- R7: In run, one full forced period with no strobe gives fault-wait.
- R8: Fault-wait drives `fault_o`=1 and `enable_o`=0 for RETRY_CYCLES clocks, then restarts at align.
- R9: When `run_req_i` is 0, the mode is idle on the next clock, with `enable_o` and `fault_o` at 0, whatever the current mode.
- R10: `enable_o` is 1 in align, ramp and run, and 0 in idle and fault-wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req_i | input | 1 | Speed command above start threshold |
| zc_i | input | 1 | Back-EMF zero-cross strobe, one clock per commutation |
| fst_sel_i | input | 2 | Forced rate select: 2'b1x high, 2'b01 middle, 2'b00 low |
| fmax_hi_i | input | 1 | Over-speed limit select, 1 = higher limit |
| align_cycles_i | input | CNT_W | DC-excitation duration in clocks |
| ramp_cycles_i | input | CNT_W | Open-loop ramp time budget in clocks |
| mode_o | output | 3 | Current phase (encoding in R1) |
| step_o | output | 1 | Forced commutation step strobe |
| enable_o | output | 1 | Power stage enable |
| fault_o | output | 1 | Fault-wait indicator |

## Verification
The bench drives the supervisor with strobe trains of three kinds. Trains slower than the forced period must not hand over, and trains faster than it must. In run, trains inside the allowed window must hold the mode, trains just below the over-speed limit must trip it under both limit settings, and stopping the strobes must trip the under-speed check. A start with no strobes at all exercises the ramp timeout, the exact count of step pulses and the retry wait. Dropping the run request in the middle of fault-wait, ramp and run confirms the immediate return to idle from each of them.

// File: rtl/bss_pkg.sv
package bss_pkg;
    typedef enum logic [2:0] {
        MODE_IDLE  = 3'd0,
        MODE_ALIGN = 3'd1,
        MODE_RAMP  = 3'd2,
        MODE_RUN   = 3'd3,
        MODE_FAULT = 3'd4
    } mode_e;
endpackage

// File: rtl/bss_rate_sel.sv
module bss_rate_sel #(
    parameter int CNT_W      = 32,
    parameter int FST_SHIFT  = 16,
    parameter int FMAX_SHIFT = 11
) (
    input  logic [1:0]       fst_sel_i,
    input  logic             fmax_hi_i,
    output logic [CNT_W-1:0] forced_per_o,
    output logic [CNT_W-1:0] max_per_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        unique casez (fst_sel_i)
            2'b1?:   forced_per_o = ONE << FST_SHIFT;
            2'b01:   forced_per_o = ONE << (FST_SHIFT + 1);
            default: forced_per_o = ONE << (FST_SHIFT + 2);
        endcase
        max_per_o = fmax_hi_i ? (ONE << FMAX_SHIFT) : (ONE << (FMAX_SHIFT + 1));
    end
endmodule

// File: rtl/bss_step_gen.sv
module bss_step_gen #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             step_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } step_st_t;

    step_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pulse = 1'b0;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == period_i - 1'b1) begin
            st_d.cnt   = '0;
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_o = st_q.pulse;
endmodule

// File: rtl/bss_gap_meter.sv
module bss_gap_meter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             zc_i,
    output logic [CNT_W-1:0] gap_o,
    output logic             seen_o
);
    typedef struct packed {
        logic [CNT_W-1:0] gap;
        logic             seen;
    } gap_st_t;

    gap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.gap  = '0;
            st_d.seen = 1'b0;
        end else if (zc_i) begin
            st_d.gap  = '0;
            st_d.seen = 1'b1;
        end else if (st_q.gap != '1) begin
            st_d.gap = st_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gap_o  = st_q.gap;
    assign seen_o = st_q.seen;
endmodule

// File: rtl/bldc_start_sup.sv
module bldc_start_sup
    import bss_pkg::*;
#(
    parameter int          CNT_W        = 32,
    parameter int          FST_SHIFT    = 16,
    parameter int          FMAX_SHIFT   = 11,
    parameter int unsigned RETRY_CYCLES = 4_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req_i,
    input  logic             zc_i,
    input  logic [1:0]       fst_sel_i,
    input  logic             fmax_hi_i,
    input  logic [CNT_W-1:0] align_cycles_i,
    input  logic [CNT_W-1:0] ramp_cycles_i,
    output logic [2:0]       mode_o,
    output logic             step_o,
    output logic             enable_o,
    output logic             fault_o
);
    localparam logic [CNT_W-1:0] RETRY_C = CNT_W'(RETRY_CYCLES);

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] tmr;
    } sup_st_t;

    sup_st_t st_d, st_q;

    logic [CNT_W-1:0] forced_per;
    logic [CNT_W-1:0] max_per;
    logic [CNT_W-1:0] gap;
    logic             seen;
    logic             step_en;
    logic             gap_restart;
    logic [CNT_W:0]   interval;
    logic [CNT_W-1:0] tmr_inc;
    logic             slow_strobe_ok;
    logic             too_fast;
    logic             too_slow;

    bss_rate_sel #(
        .CNT_W      (CNT_W),
        .FST_SHIFT  (FST_SHIFT),
        .FMAX_SHIFT (FMAX_SHIFT)
    ) u_rate (
        .fst_sel_i    (fst_sel_i),
        .fmax_hi_i    (fmax_hi_i),
        .forced_per_o (forced_per),
        .max_per_o    (max_per)
    );

    bss_gap_meter #(.CNT_W(CNT_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (gap_restart),
        .zc_i      (zc_i),
        .gap_o     (gap),
        .seen_o    (seen)
    );

    bss_step_gen #(.CNT_W(CNT_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (step_en),
        .period_i (forced_per),
        .step_o   (step_o)
    );

    // Interval in clocks between the previous strobe and a strobe now.
    assign interval       = {1'b0, gap} + 1'b1;
    assign tmr_inc        = st_q.tmr + 1'b1;
    assign slow_strobe_ok = seen && (interval < {1'b0, forced_per});
    assign too_fast       = interval < {1'b0, max_per};
    assign too_slow       = interval >= {1'b0, forced_per};
    assign gap_restart    = !(st_q.mode == MODE_RAMP || st_q.mode == MODE_RUN);
    assign step_en        = (st_q.mode == MODE_RAMP) && (st_d.mode == MODE_RAMP);

    always_comb begin
        st_d = st_q;
        if (!run_req_i) begin
            st_d.mode = MODE_IDLE;
            st_d.tmr  = '0;
        end else begin
            unique case (st_q.mode)
                MODE_IDLE: begin
                    st_d.mode = MODE_ALIGN;
                    st_d.tmr  = '0;
                end
                MODE_ALIGN: begin
                    if (tmr_inc >= align_cycles_i) begin
                        st_d.mode = MODE_RAMP;
                        st_d.tmr  = '0;
                    end else begin
                        st_d.tmr = tmr_inc;
                    end
                end
                MODE_RAMP: begin
                    if (zc_i && slow_strobe_ok) begin
                        st_d.mode = MODE_RUN;
                        st_d.tmr  = '0;
                    end else if (tmr_inc >= ramp_cycles_i) begin
                        st_d.mode = MODE_FAULT;
                        st_d.tmr  = '0;
                    end else begin
                        st_d.tmr = tmr_inc;
                    end
                end
                MODE_RUN: begin
                    if (zc_i ? too_fast : too_slow) begin
                        st_d.mode = MODE_FAULT;
                        st_d.tmr  = '0;
                    end
                end
                MODE_FAULT: begin
                    if (tmr_inc >= RETRY_C) begin
                        st_d.mode = MODE_ALIGN;
                        st_d.tmr  = '0;
                    end else begin
                        st_d.tmr = tmr_inc;
                    end
                end
                default: begin
                    st_d.mode = MODE_IDLE;
                    st_d.tmr  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_IDLE;
            st_q.tmr  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o   = st_q.mode;
    assign enable_o = (st_q.mode == MODE_ALIGN) || (st_q.mode == MODE_RAMP) ||
                      (st_q.mode == MODE_RUN);
    assign fault_o  = (st_q.mode == MODE_FAULT);
endmodule

// File: rtl/bss_checker.sv
module bss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run_req_i,
    input logic       zc_i,
    input logic [2:0] mode_o,
    input logic       step_o,
    input logic       enable_o,
    input logic       fault_o
);
    AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_req_i |=> (mode_o == 3'd0 && !enable_o && !fault_o)); // R9

    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && run_req_i) |=> (mode_o == 3'd1)); // R2

    AST_STEP_IN_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (mode_o == 3'd2)); // R3

    AST_RUN_FROM_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 3'd3) |=> (mode_o != 3'd3 || $past(mode_o) == 3'd2)); // R4

    AST_RUN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_o == 3'd3) |-> $past(zc_i)); // R4

    AST_FAULT_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !enable_o); // R8

    AST_FAULT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4 && run_req_i) |=> (mode_o == 3'd4 || mode_o == 3'd1)); // R8
endmodule

bind bldc_start_sup bss_checker u_bss_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req_i (run_req_i),
    .zc_i      (zc_i),
    .mode_o    (mode_o),
    .step_o    (step_o),
    .enable_o  (enable_o),
    .fault_o   (fault_o)
);

// File: tb/bldc_start_sup_bench.sv
`timescale 1ns/1ps
module bldc_start_sup_bench;
    localparam int CNT_W = 32;
    localparam int FSH   = 4;
    localparam int MSH   = 2;
    localparam int RETRY = 50;
    localparam int ALIGN = 5;
    localparam int RAMPB = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 1'b0;
    logic zc = 1'b0;
    logic [1:0] fst_sel = 2'b11;
    logic fmax_hi = 1'b1;
    logic [CNT_W-1:0] align_cyc = CNT_W'(ALIGN);
    logic [CNT_W-1:0] ramp_cyc = CNT_W'(RAMPB);
    logic [2:0] mode_o;
    logic step_o, enable_o, fault_o;

    always #2.5 clk = ~clk;

    bldc_start_sup #(
        .CNT_W(CNT_W), .FST_SHIFT(FSH), .FMAX_SHIFT(MSH), .RETRY_CYCLES(RETRY)
    ) u_bldc_start_sup (
        .clk(clk), .rst_n(rst_n), .run_req_i(run_req), .zc_i(zc),
        .fst_sel_i(fst_sel), .fmax_hi_i(fmax_hi),
        .align_cycles_i(align_cyc), .ramp_cycles_i(ramp_cyc),
        .mode_o(mode_o), .step_o(step_o), .enable_o(enable_o), .fault_o(fault_o)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // Behavioural reference: phase number, timers as integers.
    int m_mode, m_tmr, m_cnt, m_gap;
    bit m_step, m_seen;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_tmr = 0; m_cnt = 0; m_gap = 0; m_step = 0; m_seen = 0;
        end else begin
            int fper, mper, nmode, ntmr, ival;
            fper  = 1 << (FSH + (fst_sel[1] ? 0 : (fst_sel[0] ? 1 : 2)));
            mper  = fmax_hi ? (1 << MSH) : (1 << (MSH + 1));
            ival  = m_gap + 1;
            nmode = m_mode;
            ntmr  = m_tmr + 1;
            if (!run_req) begin
                nmode = 0; ntmr = 0;
            end else if (m_mode == 0) begin
                nmode = 1; ntmr = 0;
            end else if (m_mode == 1) begin
                if (ntmr >= int'(align_cyc)) begin nmode = 2; ntmr = 0; end
            end else if (m_mode == 2) begin
                if (zc && m_seen && ival < fper) begin nmode = 3; ntmr = 0; end
                else if (ntmr >= int'(ramp_cyc)) begin nmode = 4; ntmr = 0; end
            end else if (m_mode == 3) begin
                ntmr = m_tmr;
                if ((zc && ival < mper) || (!zc && ival >= fper)) begin
                    nmode = 4; ntmr = 0;
                end
            end else begin
                if (ntmr >= RETRY) begin nmode = 1; ntmr = 0; end
            end
            m_step = 0;
            if (m_mode == 2 && nmode == 2) begin
                if (m_cnt == fper - 1) begin m_cnt = 0; m_step = 1; end
                else m_cnt = m_cnt + 1;
            end else begin
                m_cnt = 0;
            end
            if (m_mode != 2 && m_mode != 3) begin m_gap = 0; m_seen = 0; end
            else if (zc) begin m_gap = 0; m_seen = 1; end
            else m_gap = m_gap + 1;
            m_mode = nmode;
            m_tmr  = ntmr;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_en, exp_fault;
            exp_en    = (m_mode >= 1 && m_mode <= 3);
            exp_fault = (m_mode == 4);
            checks++;
            if (mode_o !== 3'(m_mode) || enable_o !== exp_en ||
                fault_o !== exp_fault || step_o !== m_step) begin
                errors++;
                $display("FAIL %s R10: mode/en/fault/step actual=%0d/%0b/%0b/%0b expected=%0d/%0b/%0b/%0b",
                         tag, mode_o, enable_o, fault_o, step_o,
                         m_mode, exp_en, exp_fault, m_step);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_mode(input int m);
        int n = 0;
        while (mode_o !== 3'(m) && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_mode(input int m, output int n);
        n = 0;
        while (mode_o === 3'(m) && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic zc_train(input int gap_n, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            zc = 1'b1;
            @(negedge clk);
            zc = 1'b0;
            repeat (gap_n - 1) @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n, steps;
        repeat (3) @(negedge clk);
        chk(mode_o == 0 && !enable_o && !fault_o && !step_o, "R1 reset outputs", mode_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode_o == 0, "R1 idle after reset", mode_o, 0);

        // Start with no strobes: align length, step count, ramp timeout, retry.
        tag = "R2"; fst_sel = 2'b11; run_req = 1'b1;
        @(negedge clk);
        chk(mode_o == 1 && enable_o, "R2 align entered", mode_o, 1);
        count_mode(1, n);
        chk(n == ALIGN, "R2 align length", n, ALIGN);
        tag = "R5"; n = 0; steps = 0;
        while (mode_o === 3'd2 && n < 3000) begin
            n++;
            if (step_o) steps++;
            @(negedge clk);
        end
        chk(steps == RAMPB / 16, "R3 step pulses at period 16", steps, RAMPB / 16);
        chk(n == RAMPB, "R5 ramp budget", n, RAMPB);
        chk(mode_o == 4 && fault_o && !enable_o, "R5 timeout to fault", mode_o, 4);
        tag = "R8";
        count_mode(4, n);
        chk(n == RETRY, "R8 retry wait length", n, RETRY);
        chk(mode_o == 1, "R8 restart at align", mode_o, 1);
        wait_mode(4);
        tag = "R9"; run_req = 1'b0;
        @(negedge clk);
        chk(mode_o == 0 && !fault_o, "R9 drop during fault", mode_o, 0);

        // Middle forced rate: slow strobes hold ramp, faster ones hand over.
        tag = "R4"; fst_sel = 2'b01; run_req = 1'b1;
        wait_mode(2);
        zc_train(40, 3);
        chk(mode_o == 2, "R4 no handover at interval 40 >= 32", mode_o, 2);
        zc_train(20, 2);
        chk(mode_o == 3, "R4 handover at interval 20 < 32", mode_o, 3);
        zc_train(20, 5);
        chk(mode_o == 3, "R6 interval 20 within limits", mode_o, 3);
        tag = "R7";
        repeat (40) @(negedge clk);
        chk(mode_o == 4, "R7 under-speed fault", mode_o, 4);
        run_req = 1'b0;
        @(negedge clk);

        // Low forced rate, lower over-speed limit (8 clocks).
        tag = "R6"; fst_sel = 2'b00; fmax_hi = 1'b0; run_req = 1'b1;
        wait_mode(2);
        zc_train(30, 2);
        chk(mode_o == 3, "R4 handover at low rate", mode_o, 3);
        zc_train(10, 2);
        chk(mode_o == 3, "R6 interval 10 >= 8 keeps run", mode_o, 3);
        zc_train(6, 2);
        chk(mode_o == 4, "R6 interval 6 < 8 faults", mode_o, 4);

        // Higher over-speed limit (4 clocks) after an automatic retry.
        fmax_hi = 1'b1;
        wait_mode(2);
        zc_train(30, 2);
        zc_train(6, 2);
        chk(mode_o == 3, "R6 interval 6 >= 4 keeps run", mode_o, 3);
        zc_train(3, 2);
        chk(mode_o == 4, "R6 interval 3 < 4 faults", mode_o, 4);

        // Drop the request in ramp and in run.
        tag = "R9"; run_req = 1'b0;
        @(negedge clk);
        run_req = 1'b1;
        wait_mode(2);
        run_req = 1'b0;
        @(negedge clk);
        chk(mode_o == 0 && !enable_o, "R9 drop during ramp", mode_o, 0);
        run_req = 1'b1;
        wait_mode(2);
        zc_train(30, 2);
        run_req = 1'b0;
        @(negedge clk);
        chk(mode_o == 0 && !enable_o, "R9 drop during run", mode_o, 0);
        chk(enable_o == 0, "R10 enable off in idle", enable_o, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule